// File: doc/BRIEF.md
# Integer Multiply Unit with High-Part Variants

This block multiplies two 64-bit integers and returns one 64-bit slice of the result. It can return the low half of the product. It can also return the upper half of the 128-bit product, reading the operands as signed×signed, signed×unsigned or unsigned×unsigned. A separate word mode returns a sign-extended 32-bit product. The block serves as the multiply functional unit of an integer pipeline. The pipeline presents operands, a 3-bit operation code and a word flag with a valid strobe, and collects the result when the done strobe fires.

Internally the 128-bit product is assembled from four half-width partial products, with an explicit carry out of the middle column. In the signed high-half operations the unit multiplies operand magnitudes. It then restores the sign by complementing the upper half and adding one only when the low half of the magnitude product is zero. The unit takes two clock edges per operation: one registers the magnitudes, the other registers the result. While an operation is in flight it reports that it is not ready.

Top module: `int_mul_unit`

## Requirements
- R1: After reset `done` is 0, `in_ready` is 1 and `result` is 0.
- R2: A request is taken at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for exactly one cycle. `done` is 1 for exactly one cycle, starting at the second rising edge after the request was taken.
- R3: `func` = 0 with `word` = 0 returns bits 63:0 of the product.
- R4: `func` = 1 with `word` = 0 returns bits 127:64 of the product, with both operands read as signed.
- R5: `func` = 2 with `word` = 0 returns bits 127:64 of the product, with `op_a` read as signed and `op_b` read as unsigned.
- R6: `func` = 3 with `word` = 0 returns bits 127:64 of the product, with both operands read as unsigned.
- R7: With `word` = 1, `func` is ignored. The result is bits 31:0 of `op_a[31:0]`×`op_b[31:0]`, sign-extended from bit 31 to 64 bits.
- R8: An operand of 0x8000_0000_0000_0000 in a signed operation gives the exact product of its value −2^63, with no wrap of the magnitude.
- R9: `result` holds its value in every cycle where `done` is 0. A request presented while `in_ready` is 0 is ignored and does not change the pending result.
- R10: `func` codes 4 to 7 with `word` = 0 behave as code 0 and return bits 63:0 of the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_ready | output | 1 | Unit idle; can take a request |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| func | input | 3 | Operation code (0 low, 1 high s×s, 2 high s×u, 3 high u×u) |
| word | input | 1 | Word mode: 32-bit product, sign-extended |
| done | output | 1 | One-cycle result strobe |
| result | output | 64 | Selected product slice, held between strobes |

## Verification
A result is due at the second rising edge after the edge that takes the request. The bench drives each request on a falling edge and lets one rising edge take it. It checks at the next falling edge that `in_ready` and `done` are both low. It then lets a second rising edge pass and compares `done` and `result` at the falling edge that follows. During the busy cycle the bench keeps `in_valid` high with unrelated operands. One cycle after the strobe it checks that `done` has fallen and `result` is unchanged. The expected value of every operation comes from a 128-bit product of the operands, sign- or zero-extended in the bench.

// File: rtl/int_mul_unit.sv
module int_mul_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [2:0]      func,
  input  logic            word,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int H = XLEN / 2;

  logic            busy;
  logic [XLEN-1:0] mag_a, mag_b;
  logic            neg_q, high_q, word_q, res_word;

  wire accept = in_valid && !busy;
  wire a_sgn  = !word && (func == 3'd1 || func == 3'd2);
  wire b_sgn  = !word && (func == 3'd1);
  wire a_neg  = a_sgn && op_a[XLEN-1];
  wire b_neg  = b_sgn && op_b[XLEN-1];
  wire high   = !word && (func == 3'd1 || func == 3'd2 || func == 3'd3);

  assign in_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mag_a  <= '0;
      mag_b  <= '0;
      neg_q  <= 1'b0;
      high_q <= 1'b0;
      word_q <= 1'b0;
    end else begin
      busy <= accept;
      if (accept) begin
        mag_a  <= a_neg ? -op_a : op_a;
        mag_b  <= b_neg ? -op_b : op_b;
        neg_q  <= a_neg ^ b_neg;
        high_q <= high;
        word_q <= word;
      end
    end
  end

  logic [XLEN-1:0] p_hh, p_hl, p_lh, p_ll, mid, low, upper, upper_fix, nxt;

  assign p_hh = {{H{1'b0}}, mag_a[XLEN-1:H]} * {{H{1'b0}}, mag_b[XLEN-1:H]};
  assign p_hl = {{H{1'b0}}, mag_a[XLEN-1:H]} * {{H{1'b0}}, mag_b[H-1:0]};
  assign p_lh = {{H{1'b0}}, mag_a[H-1:0]}    * {{H{1'b0}}, mag_b[XLEN-1:H]};
  assign p_ll = {{H{1'b0}}, mag_a[H-1:0]}    * {{H{1'b0}}, mag_b[H-1:0]};

  assign mid   = {{H{1'b0}}, p_hl[H-1:0]} + {{H{1'b0}}, p_lh[H-1:0]}
               + {{H{1'b0}}, p_ll[XLEN-1:H]};
  assign low   = {mid[H-1:0], p_ll[H-1:0]};
  assign upper = p_hh + {{H{1'b0}}, p_hl[XLEN-1:H]}
               + {{H{1'b0}}, p_lh[XLEN-1:H]} + {{H{1'b0}}, mid[XLEN-1:H]};

  assign upper_fix = neg_q ? (~upper + {{(XLEN-1){1'b0}}, (low == '0)}) : upper;
  assign nxt = word_q ? {{H{low[H-1]}}, low[H-1:0]} : (high_q ? upper_fix : low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      result   <= '0;
      res_word <= 1'b0;
    end else begin
      done <= busy;
      if (busy) begin
        result   <= nxt;
        res_word <= word_q;
      end
    end
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_done_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 done);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  p_word_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_word) |-> (result[XLEN-1:H] == {H{result[H-1]}}));
endmodule

// File: tb/tb_int_mul_unit.sv
module tb_int_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] op_a = '0, op_b = '0;
  logic [2:0]  func = '0;
  logic        word = 1'b0;
  logic        done;
  logic [63:0] result;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  int_mul_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .func(func), .word(word),
    .done(done), .result(result)
  );

  function automatic logic [63:0] ref_mul(logic [63:0] a, logic [63:0] b,
                                          logic [2:0] f, logic w);
    logic [127:0] ea, eb, p;
    logic [63:0]  lw;
    if (w) begin
      lw = {32'b0, a[31:0]} * {32'b0, b[31:0]};
      return {{32{lw[31]}}, lw[31:0]};
    end
    ea = {{64{(f == 3'd1 || f == 3'd2) && a[63]}}, a};
    eb = {{64{(f == 3'd1) && b[63]}}, b};
    p  = ea * eb;
    if (f == 3'd1 || f == 3'd2 || f == 3'd3) return p[127:64];
    return p[63:0];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [63:0] a, logic [63:0] b, logic [2:0] f, logic w,
                     string tag);
    logic [63:0] exp;
    exp = ref_mul(a, b, f, w);
    @(negedge clk);
    check("R2 ready before request", {63'b0, in_ready}, 64'd1);
    in_valid = 1'b1; op_a = a; op_b = b; func = f; word = w;
    @(posedge clk);
    @(negedge clk);
    check("R2 ready low while busy", {63'b0, in_ready}, 64'd0);
    check("R2 done low while busy", {63'b0, done}, 64'd0);
    op_a = ~a; op_b = a ^ b; func = f ^ 3'd1; word = ~w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 done strobe", {63'b0, done}, 64'd1);
    check(tag, result, exp);
    @(negedge clk);
    check("R2 done single cycle", {63'b0, done}, 64'd0);
    check("R9 result held", result, exp);
  endtask

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 done at reset", {63'b0, done}, 64'd0);
    check("R1 ready at reset", {63'b0, in_ready}, 64'd1);
    check("R1 result at reset", result, 64'd0);
    rst_n = 1'b1;

    for (int f = 0; f < 4; f++) begin
      run(64'd0, ONES, 3'(f), 1'b0, "R3-R6 zero operand");
      run(ONES, 64'd1, 3'(f), 1'b0, "R4/R5 minus one by one");
      run(ONES, ONES, 3'(f), 1'b0, "R6 all ones");
      run(MINV, MINV, 3'(f), 1'b0, "R8 most negative squared");
      run(MINV, ONES, 3'(f), 1'b0, "R8 most negative by all ones");
      run(MINV, 64'd1, 3'(f), 1'b0, "R8 most negative by one");
    end
    run(64'hFFFF_FFFF_0000_0000, 64'd1, 3'd1, 1'b0, "R4 negative with zero low word");
    run(64'hFFFF_FFFF_0000_0000, 64'd1, 3'd2, 1'b0, "R5 negative with zero low word");
    run(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 3'd0, 1'b0, "R3 low product");
    run(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 3'd3, 1'b0, "R6 unsigned high");
    run(64'h0000_0000_7FFF_FFFF, 64'd2, 3'd0, 1'b1, "R7 word overflow to negative");
    run(64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0003, 3'd3, 1'b1, "R7 word ignores func and high halves");
    run(64'hFFFF_0000_1234_5678, 64'hDEAD_0000_8000_0000, 3'd1, 1'b1, "R7 word ignores signed code");
    for (int f = 4; f < 8; f++)
      run(64'hF0F0_1234_5678_9ABC, 64'h8765_4321_0FED_CBA9, 3'(f), 1'b0, "R10 upper codes give low product");

    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      logic [2:0]  f;
      logic        w;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 5 == 0) a[63:32] = '1;
      if (i % 7 == 0) b[31:0] = '0;
      f = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 5) == 0);
      run(a, b, f, w, "R3-R7 random operation");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule